// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A clocked static memory model with a registered address/control stage, a pipelined read stage and a two-bit burst sequencer. Every rising edge captures the address, two active-low burst-start strobes (one meant for a processor, one for a memory controller), the active-low chip select, the active-low burst-advance input, two active-low lane write enables, an active-low write-all input and the write data. A word is 18 bits, arranged as two 9-bit lanes: lane 0 is `wdata[8:0]` (bit 8 its parity bit) and lane 1 is `wdata[17:9]` (bit 17 its parity bit). Parity bits are stored and returned; they are not computed.

The controller is a three-state machine holding the kind of access registered on the last edge: `ACC_IDLE`, `ACC_READ` or `ACC_WRITE`. Its transitions are: *begin* (either strobe low with `sel_n` low) enters `ACC_WRITE` when any write enable is low, else `ACC_READ`, loads the address and clears the beat count; *drop* (either strobe low with `sel_n` high) returns to `ACC_IDLE` from any state; *continue* (no strobe, state not `ACC_IDLE`) stays busy, re-deciding read or write from the write enables, and steps the beat count only when `adv_n` is low; with no strobe in `ACC_IDLE` the machine stays idle. The second stage performs the array write or read one edge later, so read data reaches `rdata` after the second rising edge following the address. `out_en_n` gates `rdata_oe` combinationally. The tri-state bus is split into `wdata`, `rdata` and `rdata_oe`.

Top module: `sram_pipe_burst`

## Requirements
- R1: After reset `rdata_oe` is low, and stays low until a read has been started, even with `out_en_n` low.
- R2: A strobe on either `strb_cpu_n` or `strb_ctl_n` with `sel_n` low and all write enables high starts a read of `addr`; its word drives `rdata` with `rdata_oe` high after the second rising edge following the strobe edge, and not after the first.
- R3: With `order_il` low, beat k of a burst accesses the start address with its two low bits replaced by (start low bits + k) mod 4; higher bits do not change.
- R4: With `order_il` high, beat k accesses the start address with its two low bits replaced by (start low bits XOR k).
- R5: The beat count steps only on continue edges with `adv_n` low; a continue edge with `adv_n` high accesses the same address again.
- R6: A read burst delivers one word per clock cycle on consecutive cycles.
- R7: A write with `all_we_n` high writes lane i (data and parity bit) only when `lane_we_n[i]` is low; the other lane keeps its old content.
- R8: `all_we_n` low writes both lanes whatever `lane_we_n` holds.
- R9: A strobe arriving during a burst ends it and starts a new access at the new address with the beat count at zero.
- R10: `out_en_n` high forces `rdata_oe` low at once, without a clock edge, and lowering it again restores the pending word.
- R11: A deselect on the edge right after a read still lets that read's word appear for one cycle, and `rdata_oe` is low after the rising edge following the deselect edge.
- R12: A write access never raises `rdata_oe`.
- R13: After a deselect, edges with no strobe start nothing, even with `adv_n` low, and `rdata_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | AW | Word address, sampled with a strobe |
| strb_cpu_n | input | 1 | Active-low burst start, processor side |
| strb_ctl_n | input | 1 | Active-low burst start, controller side |
| sel_n | input | 1 | Active-low chip select, sampled with a strobe |
| adv_n | input | 1 | Active-low burst advance |
| lane_we_n | input | LANES | Active-low per-lane write enables |
| all_we_n | input | 1 | Active-low write of every lane |
| order_il | input | 1 | Burst order: 1 interleaved, 0 linear |
| out_en_n | input | 1 | Active-low asynchronous output enable |
| wdata | input | LANES*LANE_W | Write data, lane-ordered |
| rdata | output | LANES*LANE_W | Read data |
| rdata_oe | output | 1 | High when rdata would drive the bus |

## Verification
On every cycle the assertions check that a begin loads the presented address into the burst address, that the sequencer steps by one in linear order and holds when not stepped, that a deselect empties the access register on the next edge and the output stage one edge later, that a started read yields a valid word two edges on, and that a started write never does. Only the bench scenarios can show stored contents: lane masking, write-all, the actual linear and interleaved address orders against a reference memory, burst aborts, and the immediate effect of the output enable between edges.

// File: rtl/sram_pipe_pkg.sv
package sram_pipe_pkg;
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;
endpackage

// File: rtl/sram_burst_seq.sv
module sram_burst_seq #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic          step,
    input  logic          interleave,
    input  logic [CW-1:0] start_bits,
    output logic [CW-1:0] beat_bits
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ld) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        if (interleave) begin
            beat_bits = start_bits ^ cnt_q;
        end else begin
            beat_bits = start_bits + cnt_q;
        end
    end

    // R3: a linear step advances the beat address by one, wrapping
    a_r3_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld && !interleave) |=>
            (interleave || beat_bits == $past(beat_bits) + 1'b1));

    // R5: without step or load the beat address holds
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !ld) |=>
            ($past(interleave) != interleave || $stable(beat_bits)));
endmodule

// File: rtl/sram_acc_ctrl.sv
module sram_acc_ctrl
    import sram_pipe_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      strb_cpu_n,
    input  logic                      strb_ctl_n,
    input  logic                      sel_n,
    input  logic                      adv_n,
    input  logic [LANES-1:0]          lane_we_n,
    input  logic                      all_we_n,
    input  logic [AW-1:0]             addr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output acc_e                      acc,
    output logic [AW-1:0]             base_q,
    output logic [LANES-1:0]          lane_wr_q,
    output logic [LANES*LANE_W-1:0]   wdata_q,
    output logic                      ld,
    output logic                      step
);
    localparam int DW = LANES * LANE_W;

    acc_e acc_q, acc_nxt;
    logic strobe, begin_acc, drop, cont, wr_req;

    always_comb begin
        strobe    = !strb_cpu_n || !strb_ctl_n;
        begin_acc = strobe && !sel_n;
        drop      = strobe && sel_n;
        wr_req    = !all_we_n || (lane_we_n != {LANES{1'b1}});
        cont      = !strobe && (acc_q != ACC_IDLE);
        ld        = begin_acc;
        step      = cont && !adv_n;
    end

    always_comb begin
        acc_nxt = acc_q;
        unique case (acc_q)
            ACC_IDLE: begin
                if (begin_acc) acc_nxt = wr_req ? ACC_WRITE : ACC_READ;
                else           acc_nxt = ACC_IDLE;
            end
            ACC_READ, ACC_WRITE: begin
                if (drop) acc_nxt = ACC_IDLE;
                else      acc_nxt = wr_req ? ACC_WRITE : ACC_READ;
            end
            default: acc_nxt = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= ACC_IDLE;
        else        acc_q <= acc_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q    <= '0;
            lane_wr_q <= '0;
            wdata_q   <= '0;
        end else begin
            if (begin_acc) base_q <= addr;
            if (begin_acc || cont) begin
                lane_wr_q <= all_we_n ? ~lane_we_n : {LANES{1'b1}};
                wdata_q   <= wdata;
            end
        end
    end

    assign acc = acc_q;

    // R13: a deselect empties the access register on the next edge
    a_r13_drop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> (acc == ACC_IDLE));

    // R9: a begin always yields a busy access register
    a_r9_begin_busy: assert property (@(posedge clk) disable iff (!rst_n)
        begin_acc |=> (acc != ACC_IDLE));

    logic [DW-1:0] unused_w;
    assign unused_w = '0;
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
    import sram_pipe_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  acc_e                     acc,
    input  logic [AW-1:0]            word_addr,
    input  logic [LANES-1:0]         lane_wr,
    input  logic [LANES*LANE_W-1:0]  wdata,
    output logic [LANES*LANE_W-1:0]  rd_q,
    output logic                     rd_vld
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_lane;

        always_ff @(posedge clk) begin
            if (acc == ACC_WRITE && lane_wr[g]) begin
                mem[word_addr] <= wdata[g*LANE_W +: LANE_W];
            end
            if (acc == ACC_READ) begin
                rd_lane <= mem[word_addr];
            end
        end

        assign rd_q[g*LANE_W +: LANE_W] = rd_lane;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_vld <= 1'b0;
        else        rd_vld <= (acc == ACC_READ);
    end
endmodule

// File: rtl/sram_pipe_burst.sv
module sram_pipe_burst
    import sram_pipe_pkg::*;
#(
    parameter int AW     = 6,
    parameter int CW     = 2,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [AW-1:0]            addr,
    input  logic                     strb_cpu_n,
    input  logic                     strb_ctl_n,
    input  logic                     sel_n,
    input  logic                     adv_n,
    input  logic [LANES-1:0]         lane_we_n,
    input  logic                     all_we_n,
    input  logic                     order_il,
    input  logic                     out_en_n,
    input  logic [LANES*LANE_W-1:0]  wdata,
    output logic [LANES*LANE_W-1:0]  rdata,
    output logic                     rdata_oe
);
    localparam int DW = LANES * LANE_W;

    acc_e            acc;
    logic [AW-1:0]   base_q;
    logic [LANES-1:0] lane_wr_q;
    logic [DW-1:0]   wdata_q;
    logic            ld, step;
    logic [CW-1:0]   beat_bits;
    logic [AW-1:0]   word_addr;
    logic            rd_vld;

    sram_acc_ctrl #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n),
        .sel_n(sel_n), .adv_n(adv_n),
        .lane_we_n(lane_we_n), .all_we_n(all_we_n),
        .addr(addr), .wdata(wdata),
        .acc(acc), .base_q(base_q), .lane_wr_q(lane_wr_q),
        .wdata_q(wdata_q), .ld(ld), .step(step)
    );

    sram_burst_seq #(.CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .ld(ld), .step(step),
        .interleave(order_il), .start_bits(base_q[CW-1:0]),
        .beat_bits(beat_bits)
    );

    assign word_addr = {base_q[AW-1:CW], beat_bits};

    sram_lane_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk(clk), .rst_n(rst_n), .acc(acc), .word_addr(word_addr),
        .lane_wr(lane_wr_q), .wdata(wdata_q),
        .rd_q(rdata), .rd_vld(rd_vld)
    );

    assign rdata_oe = rd_vld && !out_en_n;

    // Port-level decode used only by the checks below
    logic p_start, p_drop, p_wr;
    assign p_start = (!strb_cpu_n || !strb_ctl_n) && !sel_n;
    assign p_drop  = (!strb_cpu_n || !strb_ctl_n) && sel_n;
    assign p_wr    = !all_we_n || (lane_we_n != {LANES{1'b1}});

    // R2: a begin points the access at the presented address
    a_r2_load_addr: assert property (@(posedge clk) disable iff (!rst_n)
        p_start |=> (word_addr == $past(addr)));

    // R2: a started read has a valid word two edges later
    a_r2_pipe_read: assert property (@(posedge clk) disable iff (!rst_n)
        (p_start && !p_wr) |=> ##1 rd_vld);

    // R11: deselect turns the output stage off one edge after it
    a_r11_single_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        p_drop |=> ##1 !rd_vld);

    // R12: a started write never produces read data
    a_r12_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (p_start && p_wr) |=> ##1 !rd_vld);
endmodule

// File: tb/test_sram_pipe_burst.sv
`timescale 1ns/1ps
module test_sram_pipe_burst;
    localparam int AW = 6;
    localparam int DW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          strb_cpu_n = 1'b1, strb_ctl_n = 1'b1, sel_n = 1'b0, adv_n = 1'b1;
    logic [1:0]    lane_we_n = 2'b11;
    logic          all_we_n = 1'b1, order_il = 1'b0, out_en_n = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_oe;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [DW-1:0] ref_mem [int];

    always #5 clk = ~clk;

    sram_pipe_burst i_sram_pipe_burst (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n),
        .sel_n(sel_n), .adv_n(adv_n), .lane_we_n(lane_we_n),
        .all_we_n(all_we_n), .order_il(order_il), .out_en_n(out_en_n),
        .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input bit cpu, input bit ctl, input bit sel, input bit adv,
                         input logic [1:0] lanes, input bit all, input logic [AW-1:0] a,
                         input logic [DW-1:0] d);
        strb_cpu_n = cpu; strb_ctl_n = ctl; sel_n = sel; adv_n = adv;
        lane_we_n = lanes; all_we_n = all; addr = a; wdata = d;
    endtask

    task automatic idle();
        drive(1, 1, 0, 1, 2'b11, 1, '0, '0);
    endtask

    task automatic deselect();
        drive(0, 1, 1, 1, 2'b11, 1, '0, '0);
    endtask

    function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] s, input int k, input bit il);
        logic [1:0] lo;
        lo = il ? (s[1:0] ^ 2'(k)) : (s[1:0] + 2'(k));
        return {s[AW-1:2], lo};
    endfunction

    task automatic write_one(input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input logic [1:0] lanes, input bit all);
        logic [DW-1:0] old;
        @(negedge clk); drive(0, 1, 0, 1, lanes, all, a, d);
        @(negedge clk); deselect();
        old = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : '0;
        if (!all || !lanes[0]) old[8:0]  = d[8:0];
        if (!all || !lanes[1]) old[17:9] = d[17:9];
        ref_mem[int'(a)] = old;
    endtask

    // Read burst: n beats, adv_mask bit k is adv for beat k (k>0)
    task automatic read_seq(input logic [AW-1:0] s, input int n, input bit il,
                            input logic [7:0] adv_mask, input bit use_ctl, input string req);
        logic [DW-1:0] exp [8];
        int cnt = 0;
        order_il = il;
        for (int k = 0; k < n; k++) begin
            if (k > 0 && adv_mask[k]) cnt++;
            exp[k] = ref_mem[int'(beat_addr(s, cnt, il))];
        end
        for (int i = 0; i < n + 2; i++) begin
            @(negedge clk);
            if (i >= 2) chk(rdata_oe && rdata == exp[i-2], req, rdata, exp[i-2]);
            if (i == 0) drive(use_ctl, !use_ctl, 0, 1, 2'b11, 1, s, '0);
            else if (i < n) drive(1, 1, 0, !adv_mask[i], 2'b11, 1, '0, '0);
            else deselect();
        end
        @(negedge clk); idle();
        order_il = 0;
    endtask

    task automatic t_reset();
        chk(!rdata_oe, "R1 reset", {17'b0, rdata_oe}, '0);
        repeat (2) @(negedge clk);
        chk(!rdata_oe, "R1 idle after reset", {17'b0, rdata_oe}, '0);
    endtask

    task automatic t_prefill();
        for (int a = 8; a < 16; a++) write_one(AW'(a), DW'(18'h10000 + a * 18'h111), 2'b00, 1);
        write_one(6'd20, 18'h2BEEF, 2'b11, 0);
        write_one(6'd21, 18'h1CAFE, 2'b11, 0);
        @(negedge clk); idle();
    endtask

    task automatic t_single();
        // R2: timing, processor strobe
        @(negedge clk); drive(0, 1, 0, 1, 2'b11, 1, 6'd10, '0);
        @(negedge clk); deselect();
        chk(!rdata_oe, "R2 not after first edge", {17'b0, rdata_oe}, '0);
        @(negedge clk); idle();
        chk(rdata_oe && rdata == ref_mem[10], "R2 cpu strobe read", rdata, ref_mem[10]);
        read_seq(6'd13, 1, 0, 8'h00, 1, "R2 ctl strobe read");
    endtask

    task automatic t_bursts();
        read_seq(6'd9, 4, 0, 8'hFF, 0, "R3 R6 linear burst");
        read_seq(6'd9, 4, 1, 8'hFF, 1, "R4 interleaved burst");
        read_seq(6'd14, 4, 1, 8'hFF, 0, "R4 interleaved start 2");
        read_seq(6'd12, 4, 0, 8'b1100, 0, "R5 advance hold");
    endtask

    task automatic t_lanes();
        write_one(6'd30, 18'h3FFFF, 2'b00, 1);
        write_one(6'd30, 18'h00000, 2'b10, 1);
        read_seq(6'd30, 1, 0, 8'h00, 0, "R7 lane 0 only");
        write_one(6'd30, 18'h3FFFF, 2'b01, 1);
        read_seq(6'd30, 1, 0, 8'h00, 0, "R7 lane 1 only");
        write_one(6'd30, 18'h15A5A, 2'b11, 0);
        read_seq(6'd30, 1, 0, 8'h00, 0, "R8 write all");
        chk(ref_mem[30] == 18'h15A5A, "R8 reference", ref_mem[30], 18'h15A5A);
    endtask

    task automatic t_abort();
        logic [DW-1:0] exp [4];
        exp[0] = ref_mem[8]; exp[1] = ref_mem[9]; exp[2] = ref_mem[20]; exp[3] = ref_mem[21];
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i >= 2) chk(rdata_oe && rdata == exp[i-2], "R9 abort reload", rdata, exp[i-2]);
            case (i)
                0: drive(0, 1, 0, 1, 2'b11, 1, 6'd8, '0);
                1: drive(1, 1, 0, 0, 2'b11, 1, '0, '0);
                2: drive(1, 0, 0, 1, 2'b11, 1, 6'd20, '0);
                3: drive(1, 1, 0, 0, 2'b11, 1, '0, '0);
                default: deselect();
            endcase
        end
        @(negedge clk); idle();
    endtask

    task automatic t_oe();
        @(negedge clk); drive(0, 1, 0, 1, 2'b11, 1, 6'd11, '0);
        @(negedge clk); deselect();
        @(negedge clk); idle();
        #1 out_en_n = 1;
        #1 chk(!rdata_oe, "R10 async disable", {17'b0, rdata_oe}, '0);
        out_en_n = 0;
        #1 chk(rdata_oe && rdata == ref_mem[11], "R10 re-enable", rdata, ref_mem[11]);
    endtask

    task automatic t_scd();
        @(negedge clk); drive(0, 1, 0, 1, 2'b11, 1, 6'd15, '0);
        @(negedge clk); deselect();
        @(negedge clk); drive(1, 1, 0, 0, 2'b11, 1, '0, '0);
        chk(rdata_oe && rdata == ref_mem[15], "R11 last word shown", rdata, ref_mem[15]);
        @(negedge clk); idle();
        chk(!rdata_oe, "R11 off one clock after deselect", {17'b0, rdata_oe}, '0);
        @(negedge clk);
        chk(!rdata_oe, "R13 no restart after deselect", {17'b0, rdata_oe}, '0);
    endtask

    task automatic t_write_quiet();
        @(negedge clk); drive(0, 1, 0, 0, 2'b11, 0, 6'd40, 18'h00123);
        @(negedge clk); drive(1, 1, 0, 0, 2'b11, 0, '0, 18'h00456);
        chk(!rdata_oe, "R12 write quiet 1", {17'b0, rdata_oe}, '0);
        @(negedge clk); deselect();
        chk(!rdata_oe, "R12 write quiet 2", {17'b0, rdata_oe}, '0);
        @(negedge clk); idle();
        chk(!rdata_oe, "R12 write quiet 3", {17'b0, rdata_oe}, '0);
        ref_mem[40] = 18'h00123; ref_mem[41] = 18'h00456;
        read_seq(6'd40, 2, 0, 8'hFF, 0, "R12 write burst stored");
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_prefill();
        t_single();
        t_bursts();
        t_lanes();
        t_abort();
        t_oe();
        t_scd();
        t_write_quiet();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule